// File: doc/BRIEF.md
# UART Line Status Logic

This block builds the eight-bit status word that a host polls to follow a FIFO-based UART. On the receive side it holds incoming bytes in a queue of up to 32 entries. Each entry carries a three-bit error tag (parity, framing, break) beside its data. The status word shows the tags of the byte at the head of the queue. A separate summary bit shows whether any byte still in the queue carries an error. A sticky overrun flag records a push that arrived while the queue was full. On the transmit side the block turns the transmit FIFO occupancy and the shift-register busy flag into two emptiness bits.

The serial framer pushes received bytes together with their tags. The host pops bytes and reads the status word. A status read is signalled by a one-cycle strobe. That read clears the overrun flag and hides the head-byte error bits until a new byte reaches the head. The status word is built combinationally from registered state and from the transmit inputs. A push, pop or read therefore becomes visible in the cycle after the clock edge that takes it.

Top module: `line_status_word`

## Requirements
- R1: statusWord[0] is 1 exactly when the receive queue holds at least one byte.
- R2: While the head tags are not hidden, statusWord[2] is the parity tag (rxErrTag[0]), statusWord[3] is the framing tag (rxErrTag[1]) and statusWord[4] is the break tag (rxErrTag[2]) of the byte at the head of the queue. All three bits are 0 when the queue is empty.
- R3: statusRead hides bits 4:2 from the next cycle on. A new head byte makes them visible again. A new head byte comes from a valid pop, or from a push into an empty queue. When a read and a head change fall in the same cycle, the head change wins.
- R4: statusWord[1] (overrun) becomes 1 after rxPush while the queue holds 32 bytes and rxPop is low. That byte is discarded. The flag clears after statusRead. If a new overrun and a read fall in the same cycle, the flag is set.
- R5: statusWord[7] is 1 exactly when at least one stored byte has a nonzero tag. statusRead does not change it.
- R6: statusWord[5] is 1 exactly when txFifoCount is zero.
- R7: statusWord[6] is 1 exactly when txFifoCount is zero and txShiftBusy is low.
- R8: Bytes leave in arrival order, and rxHeadData shows the head byte while the queue is not empty. A pop on an empty queue is ignored. A push and a pop in the same cycle on a full queue are both accepted.
- R9: After reset the queue is empty and bits 0 to 4 and bit 7 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxPush | input | 1 | Push a received byte |
| rxData | input | 8 | Received byte |
| rxErrTag | input | 3 | Error tag of the byte: bit0 parity, bit1 framing, bit2 break |
| rxPop | input | 1 | Host removes the head byte |
| statusRead | input | 1 | Host reads the status word |
| txFifoCount | input | 6 | Transmit FIFO occupancy |
| txShiftBusy | input | 1 | Transmit shift register still holds bits |
| rxHeadData | output | 8 | Byte at the head of the receive queue |
| statusWord | output | 8 | Line status word |

## Verification
The assertions assume that the receive strobes are well-formed single-cycle levels that are sampled only at the clock edge. They also assume that txFifoCount is a plain occupancy value and makes no claim about receive state. The stimulus drives every input only after the falling edge, so inputs are stable across each rising edge. It mixes fill-heavy and drain-heavy phases, so that both the full-queue overrun and the pop-on-empty case occur. Pushes, pops and reads are randomised independently, so that reads collide with head changes and overruns in the same cycle.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic doPush;
    logic doPop;
  } lswStrobe_t;

  localparam int TAG_PARITY  = 0;
  localparam int TAG_FRAMING = 1;
  localparam int TAG_BREAK   = 2;
endpackage

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
  import lsw_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             statusRead,
  output lswStrobe_t       strobe,
  output logic [CNT_W-1:0] rxCount,
  output logic             overrun,
  output logic             tagsHidden
);
  logic isFull, isEmpty, ovrSet, headChange;

  assign isFull     = (rxCount == CNT_W'(DEPTH));
  assign isEmpty    = (rxCount == '0);
  assign strobe.doPop  = rxPop && !isEmpty;
  assign strobe.doPush = rxPush && (!isFull || rxPop);
  assign ovrSet     = rxPush && isFull && !rxPop;
  assign headChange = strobe.doPop || (strobe.doPush && isEmpty);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCount    <= '0;
      overrun    <= 1'b0;
      tagsHidden <= 1'b0;
    end else begin
      rxCount <= rxCount + CNT_W'(strobe.doPush) - CNT_W'(strobe.doPop);
      if (ovrSet)          overrun <= 1'b1;
      else if (statusRead) overrun <= 1'b0;
      if (headChange)      tagsHidden <= 1'b0;
      else if (statusRead) tagsHidden <= 1'b1;
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));

  assert_overrun_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && isFull && !rxPop) |=> (overrun && rxCount == CNT_W'(DEPTH)));

  assert_read_clears_overrun_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !(rxPush && isFull && !rxPop)) |=> !overrun);

  assert_read_hides_tags_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !rxPop && !(rxPush && isEmpty)) |=> tagsHidden);
endmodule

// File: rtl/lsw_datapath.sv
module lsw_datapath
  import lsw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAG_W  = 3,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ENT_W = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lswStrobe_t        strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [TAG_W-1:0]  inTag,
  output logic [DATA_W-1:0] headData,
  output logic [TAG_W-1:0]  headTag,
  output logic              anyErr
);
  logic [ENT_W-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] errCount;
  logic             addErr, dropErr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign {headTag, headData} = store[rdPtr];
  assign addErr  = strobe.doPush && (|inTag);
  assign dropErr = strobe.doPop && (|headTag);
  assign anyErr  = (errCount != '0);

  always_ff @(posedge clk) begin
    if (strobe.doPush) store[wrPtr] <= {inTag, inData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      errCount <= '0;
    end else begin
      if (strobe.doPush) wrPtr <= nextPtr(wrPtr);
      if (strobe.doPop)  rdPtr <= nextPtr(rdPtr);
      errCount <= errCount + CNT_W'(addErr) - CNT_W'(dropErr);
    end
  end

  assert_err_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    errCount <= CNT_W'(DEPTH));
endmodule

// File: rtl/line_status_word.sv
module line_status_word
  import lsw_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int TX_CNT_W = 6,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxPush,
  input  logic [7:0]          rxData,
  input  logic [2:0]          rxErrTag,
  input  logic                rxPop,
  input  logic                statusRead,
  input  logic [TX_CNT_W-1:0] txFifoCount,
  input  logic                txShiftBusy,
  output logic [7:0]          rxHeadData,
  output logic [7:0]          statusWord
);
  lswStrobe_t       strobe;
  logic [CNT_W-1:0] rxCount;
  logic             overrun, tagsHidden, anyErr, notEmpty, txIdle;
  logic [2:0]       headTag, shownTag;

  lsw_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxPop(rxPop),
    .statusRead(statusRead), .strobe(strobe), .rxCount(rxCount),
    .overrun(overrun), .tagsHidden(tagsHidden)
  );

  lsw_datapath #(.DATA_W(8), .TAG_W(3), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(rxData),
    .inTag(rxErrTag), .headData(rxHeadData), .headTag(headTag),
    .anyErr(anyErr)
  );

  assign notEmpty = (rxCount != '0);
  assign shownTag = (notEmpty && !tagsHidden) ? headTag : 3'b000;
  assign txIdle   = (txFifoCount == '0);

  assign statusWord = {anyErr,
                       txIdle && !txShiftBusy,
                       txIdle,
                       shownTag[TAG_BREAK],
                       shownTag[TAG_FRAMING],
                       shownTag[TAG_PARITY],
                       overrun,
                       notEmpty};

  assert_summary_needs_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[0] |-> !statusWord[7]);

  assert_shift_idle_implies_holding_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[6] |-> statusWord[5]);

  assert_empty_hides_tags_R2: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[0] |-> (statusWord[4:2] == 3'b000));
endmodule

// File: tb/line_status_word_bench.sv
module line_status_word_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxPush = 1'b0, rxPop = 1'b0, statusRead = 1'b0, txShiftBusy = 1'b0;
  logic [7:0] rxData = '0;
  logic [2:0] rxErrTag = '0;
  logic [5:0] txFifoCount = '0;
  logic [7:0] rxHeadData, statusWord;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [10:0] q[$];   // {tag, data}
  bit mOvr = 0;
  bit mHid = 0;

  always #4 clk = ~clk;

  line_status_word u_line_status_word (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxData(rxData),
    .rxErrTag(rxErrTag), .rxPop(rxPop), .statusRead(statusRead),
    .txFifoCount(txFifoCount), .txShiftBusy(txShiftBusy),
    .rxHeadData(rxHeadData), .statusWord(statusWord)
  );

  task automatic chk(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0h expected %0h", req, $time, got, exp);
    end
  endtask

  task automatic modelStep();
    int  sz = q.size();
    bit  hc = 0;
    bit  ovSet = 0;
    if (rxPop && sz > 0) begin void'(q.pop_front()); hc = 1; end
    if (rxPush) begin
      if (sz == 32 && !rxPop) ovSet = 1;
      else begin
        if (sz == 0) hc = 1;
        q.push_back({rxErrTag, rxData});
      end
    end
    if (ovSet) mOvr = 1; else if (statusRead) mOvr = 0;
    if (hc) mHid = 0; else if (statusRead) mHid = 1;
  endtask

  task automatic compareAll();
    bit anyE = 0;
    logic [2:0] tg = 3'b000;
    foreach (q[i]) if (q[i][10:8] != 3'b000) anyE = 1;
    if (q.size() > 0 && !mHid) tg = q[0][10:8];
    chk("R1", statusWord[0], q.size() > 0);
    chk("R4", statusWord[1], mOvr);
    chk("R2/R3 parity", statusWord[2], tg[0]);
    chk("R2/R3 framing", statusWord[3], tg[1]);
    chk("R2/R3 break", statusWord[4], tg[2]);
    chk("R6", statusWord[5], txFifoCount == 0);
    chk("R7", statusWord[6], (txFifoCount == 0) && !txShiftBusy);
    chk("R5", statusWord[7], anyE);
    if (q.size() > 0) chk("R8", rxHeadData, q[0][7:0]);
  endtask

  task automatic cycle(input int pPush, input int pPop, input int pRead, input int pErr);
    rxPush      = ($urandom_range(99) < pPush);
    rxPop       = ($urandom_range(99) < pPop);
    statusRead  = ($urandom_range(99) < pRead);
    rxData      = 8'($urandom);
    rxErrTag    = ($urandom_range(99) < pErr) ? 3'($urandom_range(7, 1)) : 3'b000;
    txFifoCount = ($urandom_range(1) == 0) ? 6'd0 : 6'($urandom);
    txShiftBusy = 1'($urandom);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state, tx inputs zero so bits 5 and 6 are set
    chk("R9", statusWord, 8'h60);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", statusWord, 8'h60);
    // pop on empty (R8)
    for (int i = 0; i < 20; i++) cycle(10, 90, 20, 30);
    // fill to overflow (R4)
    for (int i = 0; i < 400; i++) cycle(90, 10, 10, 20);
    // mixed traffic with frequent reads (R3, R5)
    for (int i = 0; i < 1500; i++) cycle(50, 50, 30, 40);
    // full and push+pop at full
    for (int i = 0; i < 300; i++) cycle(95, 45, 5, 60);
    // drain so summary bit clears (R5)
    for (int i = 0; i < 200; i++) cycle(5, 90, 20, 50);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule